// File: doc/BRIEF.md
# Radio Timestamp Timer

This block is a 40-bit time base for a radio controller. A 16-bit fine counter steps once per clock while running and returns to zero after reaching a programmed period. A 24-bit coarse counter advances by one each time a period completes, so the pair together gives a 40-bit timestamp. When the radio logic pulses the frame-event input (a detected start-of-frame delimiter, or the end of a transmission), the full 40-bit time is stored in a capture register. Software can then read it byte by byte, and the read is coherent.

Four compare units produce single-cycle strobes for starting receive or transmit, or for raising interrupts. Two of them watch the fine counter and two watch the coarse counter. Each match sets a sticky flag. The interrupt output is the OR of the flags that are unmasked. A staged 40-bit value can be loaded into both counters with one control write. All access is through a byte-wide register port.

Top module: `rts_timer`

Register map:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit0 run; bit1 load (pulse, reads 0); bits 5:2 compare enables |
| 1 | interrupt mask | read/write | same bit layout as the flag register |
| 2 | flags | read, write 1 to clear | see flag layout below |
| 4–5 | period | read/write | low byte first |
| 8–9 | fine compare 0 | read/write | low byte first |
| 10–11 | fine compare 1 | read/write | low byte first |
| 16–18 | coarse compare 0 | read/write | low byte first |
| 19–21 | coarse compare 1 | read/write | low byte first |
| 24–28 | capture | read | 40 bits, low byte first |
| 32–36 | load stage | write only | fine bits at 32–33, coarse bits at 34–36 |

Flag layout, used by both the flag register and the interrupt mask:

| Bit | Meaning |
|---|---|
| 0 | fine compare 0 matched |
| 1 | fine compare 1 matched |
| 2 | coarse compare 0 matched |
| 3 | coarse compare 1 matched |
| 4 | coarse counter wrapped |
| 5 | capture taken |

The compare enables in control bits 5:2 follow the same unit order as flag bits 3:0. Addresses that are not mapped read as zero.

## Requirements
- R1: After a synchronous reset, the period reads 0xFFFF. Every other readable register reads 0, and cmp_o and irq_o are 0.
- R2: While run is set, the fine counter steps by one on each clock. On the clock after it holds a value at or above the period, it returns to 0.
- R3: The coarse counter advances on the same clock edge as the fine counter's return to zero. If the coarse counter was 0xFFFFFF, it becomes 0 and flag bit 4 is set.
- R4: A clock with evt_i high stores {coarse, fine}, as they were in that cycle, into capture bytes 24 to 28, low byte first. It also sets flag bit 5.
- R5: Reading address 24 with rd_en returns capture bits 7:0 and holds capture bits 39:8 for later reads of addresses 25 to 28. If an event arrives in the same cycle as that read, both the returned byte and the held bytes come from the earlier capture.
- R6: Fine compare j pulses cmp_o[j] for one cycle, and sets flag bit j, when a counting step brings the fine counter to its compare value. This needs run set and control enable bit 2+j set.
- R7: Coarse compare j pulses cmp_o[2+j], and sets flag bit 2+j, when a period completion brings the coarse counter to its compare value. This needs control enable bit 4+j set.
- R8: A compare whose enable bit is clear never pulses its strobe and never sets its flag.
- R9: Flags stay set until a 1 is written to their bit at address 2. A flag that is set and cleared in the same cycle remains set.
- R10: irq_o is high exactly when some flag bit and the same interrupt mask bit are both 1.
- R11: Writing the control register with bit 1 set loads the staged 40-bit value into both counters on that edge. That edge does not count and produces no compare strobe.
- R12: While run is clear and no load occurs, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 24 holds the upper capture bytes |
| addr | input | 6 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| evt_i | input | 1 | Frame-event strobe that triggers a capture |
| cmp_o | output | 4 | Compare strobes: fine 0, fine 1, coarse 0, coarse 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle, and both are checked.

The first pair is a frame event and a low-byte read of the capture. The bench raises evt_i and a read of address 24 in one cycle, after loading a different value into the counters. It then expects the old low byte on rdata and the old upper bytes from the following reads, while the next full read shows the new capture.

The second pair is a flag being set and cleared at once. With a zero period and a zero fine compare, a match happens on every counting step, and the bench writes a 1 to clear that flag during those steps. The flag must read back as still set. After counting stops, the same write must clear it.

A behavioural reference model running in parallel judges every cycle of both cases and of a long random phase.

// File: rtl/rts_pkg.sv
// Package: shared sizes, register addresses and bit positions of the
// radio timestamp timer. Assumes counter widths are whole bytes.
package rts_pkg;
    localparam int CNT_W  = 16;                 // fine counter width
    localparam int OVF_W  = 24;                 // coarse counter width
    localparam int TS_W   = CNT_W + OVF_W;      // timestamp width
    localparam int N_LO   = 2;                  // fine compare units
    localparam int N_HI   = 2;                  // coarse compare units
    localparam int N_CMP  = N_LO + N_HI;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int CNT_B  = (CNT_W + 7) / 8;
    localparam int OVF_B  = (OVF_W + 7) / 8;
    localparam int TS_B   = (TS_W + 7) / 8;
    localparam int FLG_W  = N_CMP + 2;
    localparam int FLG_WRAP = N_CMP;
    localparam int FLG_CAP  = N_CMP + 1;

    localparam int A_CTRL  = 0;
    localparam int A_IMASK = 1;
    localparam int A_FLAGS = 2;
    localparam int A_PER   = 4;
    localparam int A_CMPL  = 8;
    localparam int A_CMPH  = 16;
    localparam int A_CAP   = 24;
    localparam int A_LOAD  = 32;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_LOAD   = 1;
    localparam int CTRL_EN_LSB = 2;

    typedef logic [CNT_W-1:0] fine_t;
    typedef logic [OVF_W-1:0] coarse_t;
    typedef logic [TS_W-1:0]  stamp_t;
endpackage

// File: rtl/rts_base.sv
// Module: fine/coarse counter pair. Counts while run is set, returns the
// fine counter to zero after it reaches the period (or anything above it)
// and advances the coarse counter on that same edge. A load overrides
// counting. Exposes next-state values so compare units can register
// strobes that line up with the counter value.
module rts_base #(
    parameter int CW = 16,
    parameter int OW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            load,
    input  logic [CW+OW-1:0] load_val,
    input  logic [CW-1:0]   period,
    output logic [CW-1:0]   cnt_q,
    output logic [OW-1:0]   ovf_q,
    output logic [CW-1:0]   cnt_nxt,
    output logic [OW-1:0]   ovf_nxt,
    output logic            cnt_adv,
    output logic            ovf_step,
    output logic            ovf_wrap
);
    logic period_done;

    // next-state logic for both counters
    always_comb begin
        period_done = (cnt_q >= period);
        cnt_adv     = run && !load;
        ovf_step    = cnt_adv && period_done;
        ovf_wrap    = ovf_step && (&ovf_q);
        cnt_nxt     = cnt_q;
        ovf_nxt     = ovf_q;
        if (load) begin
            cnt_nxt = load_val[CW-1:0];
            ovf_nxt = load_val[CW+OW-1:CW];
        end else if (cnt_adv) begin
            cnt_nxt = period_done ? '0 : cnt_q + 1'b1;
            if (ovf_step) begin
                ovf_nxt = ovf_q + 1'b1;
            end
        end
    end

    // counter state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end
endmodule

// File: rtl/rts_cmp.sv
// Module: one compare unit. Flags a hit when an update step brings the
// watched counter to the compare value, and registers that hit as a
// one-cycle strobe aligned with the counter holding the value.
module rts_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         step,
    input  logic [W-1:0] next_val,
    input  logic [W-1:0] ref_val,
    output logic         hit,
    output logic         strobe_q
);
    // match detect on the value the counter is about to take
    always_comb begin
        hit = enable && step && (next_val == ref_val);
    end

    // strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= hit;
    end
endmodule

// File: rtl/rts_capture.sv
// Module: timestamp capture with a read-coherence holding register.
// An event stores the current timestamp; a low-byte read stores the
// upper bytes of the previous capture so later byte reads match it.
module rts_capture #(
    parameter int TW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [TW-1:0] ts_now,
    input  logic          rd_low,
    output logic [TW-1:0] cap_q,
    output logic [TW-9:0] hold_q
);
    // capture register
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (evt) cap_q <= ts_now;
    end

    // upper-byte holding register, loaded from the pre-event capture
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (rd_low) hold_q <= cap_q[TW-1:8];
    end
endmodule

// File: rtl/rts_regs.sv
// Module: byte-wide register file of the timer: control, interrupt mask,
// write-one-to-clear flags, period, compare values and load stage, plus
// the read multiplexer. Assumes all widths are whole bytes; set requests
// win over clears in the same cycle.
module rts_regs
    import rts_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [FLG_W-1:0]           flag_set,
    input  logic [TS_W-1:0]            cap_val,
    input  logic [TS_W-9:0]            cap_hold,
    output logic                       run_q,
    output logic                       load_go,
    output logic [N_CMP-1:0]           en_q,
    output logic [CNT_W-1:0]           period_q,
    output logic [N_LO-1:0][CNT_W-1:0] cmp_lo_q,
    output logic [N_HI-1:0][OVF_W-1:0] cmp_hi_q,
    output logic [TS_W-1:0]            stage_q,
    output logic [FLG_W-1:0]           flags_q,
    output logic [FLG_W-1:0]           imask_q,
    output logic                       cap_rd,
    output logic                       irq
);
    logic [FLG_W-1:0] flag_clr;

    // write strobes derived from the port
    always_comb begin
        load_go  = wr_en && (addr == ADDR_W'(A_CTRL)) && wdata[CTRL_LOAD];
        flag_clr = (wr_en && (addr == ADDR_W'(A_FLAGS))) ? wdata[FLG_W-1:0] : '0;
        cap_rd   = rd_en && (addr == ADDR_W'(A_CAP));
        irq      = |(flags_q & imask_q);
    end

    // sticky flags: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // configuration registers written byte by byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            en_q     <= '0;
            imask_q  <= '0;
            period_q <= '1;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            stage_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                run_q <= wdata[CTRL_RUN];
                en_q  <= wdata[CTRL_EN_LSB +: N_CMP];
            end
            if (addr == ADDR_W'(A_IMASK)) begin
                imask_q <= wdata[FLG_W-1:0];
            end
            for (int b = 0; b < CNT_B; b++) begin
                if (addr == ADDR_W'(A_PER + b)) period_q[8*b +: 8] <= wdata;
            end
            for (int j = 0; j < N_LO; j++) begin
                for (int b = 0; b < CNT_B; b++) begin
                    if (addr == ADDR_W'(A_CMPL + j*CNT_B + b))
                        cmp_lo_q[j][8*b +: 8] <= wdata;
                end
            end
            for (int j = 0; j < N_HI; j++) begin
                for (int b = 0; b < OVF_B; b++) begin
                    if (addr == ADDR_W'(A_CMPH + j*OVF_B + b))
                        cmp_hi_q[j][8*b +: 8] <= wdata;
                end
            end
            for (int b = 0; b < TS_B; b++) begin
                if (addr == ADDR_W'(A_LOAD + b)) stage_q[8*b +: 8] <= wdata;
            end
        end
    end

    // read multiplexer; unmapped and write-only addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))  rdata = DATA_W'({en_q, 1'b0, run_q});
        if (addr == ADDR_W'(A_IMASK)) rdata = DATA_W'(imask_q);
        if (addr == ADDR_W'(A_FLAGS)) rdata = DATA_W'(flags_q);
        for (int b = 0; b < CNT_B; b++) begin
            if (addr == ADDR_W'(A_PER + b)) rdata = period_q[8*b +: 8];
        end
        for (int j = 0; j < N_LO; j++) begin
            for (int b = 0; b < CNT_B; b++) begin
                if (addr == ADDR_W'(A_CMPL + j*CNT_B + b))
                    rdata = cmp_lo_q[j][8*b +: 8];
            end
        end
        for (int j = 0; j < N_HI; j++) begin
            for (int b = 0; b < OVF_B; b++) begin
                if (addr == ADDR_W'(A_CMPH + j*OVF_B + b))
                    rdata = cmp_hi_q[j][8*b +: 8];
            end
        end
        if (addr == ADDR_W'(A_CAP)) rdata = cap_val[7:0];
        for (int k = 1; k < TS_B; k++) begin
            if (addr == ADDR_W'(A_CAP + k)) rdata = cap_hold[8*(k-1) +: 8];
        end
    end
endmodule

// File: rtl/rts_timer.sv
// Module: top of the radio timestamp timer. Joins the counter pair, the
// fine and coarse compare units, the capture path and the register file.
// Assumes evt_i is already synchronous to clk.
module rts_timer
    import rts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt_i,
    output logic [N_CMP-1:0]  cmp_o,
    output logic              irq_o
);
    logic                       run_q, load_go, cap_rd;
    logic [N_CMP-1:0]           en_q, hits;
    logic [CNT_W-1:0]           period_q;
    logic [N_LO-1:0][CNT_W-1:0] cmp_lo_q;
    logic [N_HI-1:0][OVF_W-1:0] cmp_hi_q;
    stamp_t                     stage_q, cap_q;
    logic [TS_W-9:0]            hold_q;
    logic [FLG_W-1:0]           flags_q, imask_q, flag_set;
    fine_t                      cnt_q, cnt_nxt;
    coarse_t                    ovf_q, ovf_nxt;
    logic                       cnt_adv, ovf_step, ovf_wrap;

    rts_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .flag_set (flag_set),
        .cap_val  (cap_q),
        .cap_hold (hold_q),
        .run_q    (run_q),
        .load_go  (load_go),
        .en_q     (en_q),
        .period_q (period_q),
        .cmp_lo_q (cmp_lo_q),
        .cmp_hi_q (cmp_hi_q),
        .stage_q  (stage_q),
        .flags_q  (flags_q),
        .imask_q  (imask_q),
        .cap_rd   (cap_rd),
        .irq      (irq_o)
    );

    rts_base #(.CW(CNT_W), .OW(OVF_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .load     (load_go),
        .load_val (stage_q),
        .period   (period_q),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q),
        .cnt_nxt  (cnt_nxt),
        .ovf_nxt  (ovf_nxt),
        .cnt_adv  (cnt_adv),
        .ovf_step (ovf_step),
        .ovf_wrap (ovf_wrap)
    );

    // fine compare units watch every counting step
    for (genvar j = 0; j < N_LO; j++) begin : g_lo
        rts_cmp #(.W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (en_q[j]),
            .step     (cnt_adv),
            .next_val (cnt_nxt),
            .ref_val  (cmp_lo_q[j]),
            .hit      (hits[j]),
            .strobe_q (cmp_o[j])
        );
    end

    // coarse compare units watch period completions only
    for (genvar j = 0; j < N_HI; j++) begin : g_hi
        rts_cmp #(.W(OVF_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (en_q[N_LO+j]),
            .step     (ovf_step),
            .next_val (ovf_nxt),
            .ref_val  (cmp_hi_q[j]),
            .hit      (hits[N_LO+j]),
            .strobe_q (cmp_o[N_LO+j])
        );
    end

    rts_capture #(.TW(TS_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i),
        .ts_now ({ovf_q, cnt_q}),
        .rd_low (cap_rd),
        .cap_q  (cap_q),
        .hold_q (hold_q)
    );

    // flag set requests gathered in flag-bit order
    always_comb begin
        flag_set = {evt_i, ovf_wrap, hits};
    end
endmodule

// File: rtl/rts_checker.sv
// Module: property checker for the radio timestamp timer, bound into
// every instance of the top module.
module rts_checker
    import rts_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              evt_i,
    input logic [N_CMP-1:0]  cmp_o,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [OVF_W-1:0]  ovf_q,
    input logic [CNT_W-1:0]  period_q,
    input logic              run_q,
    input logic              load_go,
    input logic [FLG_W-1:0]  flags_q,
    input logic [FLG_W-1:0]  imask_q
);
    logic counting, finishing;
    always_comb begin
        counting  = run_q && !load_go;
        finishing = counting && (cnt_q >= period_q);
    end

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        finishing |=> (cnt_q == '0));
    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && (cnt_q < period_q)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    assert_ovf_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        finishing |=> (ovf_q == OVF_W'($past(ovf_q) + 1'b1)));
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (finishing && (&ovf_q)) |=> flags_q[FLG_WRAP]);
    assert_cap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flags_q[FLG_CAP]);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_go) |=> ($stable(cnt_q) && $stable(ovf_q)));
    assert_no_strobe_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (cmp_o == '0));
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & imask_q) == '0) |-> !irq_o);

    for (genvar i = 0; i < N_CMP; i++) begin : g_stb
        // R6 / R7: every strobe comes with its flag already set
        assert_strobe_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_o[i] |-> flags_q[i]);
    end

    for (genvar j = 0; j < N_HI; j++) begin : g_hi
        assert_hi_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_o[N_LO+j] |-> (ovf_q != $past(ovf_q)));
    end

    for (genvar i = 0; i < FLG_W; i++) begin : g_flg
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !(wr_en && (addr == ADDR_W'(A_FLAGS)) && wdata[i]))
            |=> flags_q[i]);
    end
endmodule

bind rts_timer rts_checker u_chk (.*);

// File: tb/tb_rts_timer.sv
`timescale 1ns/1ps
module tb_rts_timer;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, evt = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] cmp;
    logic       irq;
    int vecs = 0, errs = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rts_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .evt_i(evt),
                   .cmp_o(cmp), .irq_o(irq));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_cnt, m_per;
    bit [23:0] m_ovf;
    bit [39:0] m_cap, m_stage;
    bit [31:0] m_hold;
    bit        m_run;
    bit [3:0]  m_en, m_stb;
    bit [5:0]  m_flg, m_msk;
    bit [15:0] m_cl [2];
    bit [23:0] m_ch [2];

    always @(posedge clk) begin : model
        bit ld, adv, fin, wrp;
        bit [15:0] ncnt;
        bit [23:0] novf;
        bit [3:0]  nstb;
        bit [5:0]  clr;
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_per = 16'hFFFF; m_cap = 0; m_stage = 0;
            m_hold = 0; m_run = 0; m_en = 0; m_stb = 0; m_flg = 0; m_msk = 0;
            m_cl[0] = 0; m_cl[1] = 0; m_ch[0] = 0; m_ch[1] = 0;
        end else begin
            ld   = wr_en && addr == 0 && wdata[1];
            adv  = m_run && !ld;
            fin  = adv && (m_cnt >= m_per);
            wrp  = fin && (m_ovf == 24'hFFFFFF);
            ncnt = m_cnt; novf = m_ovf;
            if (ld) begin
                ncnt = m_stage[15:0]; novf = m_stage[39:16];
            end else if (adv) begin
                ncnt = fin ? 16'd0 : m_cnt + 16'd1;
                if (fin) novf = m_ovf + 24'd1;
            end
            for (int j = 0; j < 2; j++) begin
                nstb[j]   = m_en[j]   && adv && ncnt == m_cl[j];
                nstb[2+j] = m_en[2+j] && fin && novf == m_ch[j];
            end
            clr = (wr_en && addr == 2) ? wdata[5:0] : 6'd0;
            m_flg = (m_flg & ~clr) | {evt, wrp, nstb};
            if (rd_en && addr == 24) m_hold = m_cap[39:8];
            if (evt) m_cap = {m_ovf, m_cnt};
            if (wr_en) begin
                case (addr)
                    0: begin m_run = wdata[0]; m_en = wdata[5:2]; end
                    1: m_msk = wdata[5:0];
                    4: m_per[7:0] = wdata;   5: m_per[15:8] = wdata;
                    8: m_cl[0][7:0] = wdata; 9: m_cl[0][15:8] = wdata;
                    10: m_cl[1][7:0] = wdata; 11: m_cl[1][15:8] = wdata;
                    16: m_ch[0][7:0] = wdata; 17: m_ch[0][15:8] = wdata;
                    18: m_ch[0][23:16] = wdata;
                    19: m_ch[1][7:0] = wdata; 20: m_ch[1][15:8] = wdata;
                    21: m_ch[1][23:16] = wdata;
                    32, 33, 34, 35, 36: m_stage[8*(addr-32) +: 8] = wdata;
                    default: ;
                endcase
            end
            m_cnt = ncnt; m_ovf = novf; m_stb = nstb;
        end
    end

    function automatic bit [7:0] exp_rd(bit [5:0] a);
        case (a)
            0: return {2'b00, m_en, 1'b0, m_run};
            1: return {2'b00, m_msk};
            2: return {2'b00, m_flg};
            4: return m_per[7:0];     5: return m_per[15:8];
            8: return m_cl[0][7:0];   9: return m_cl[0][15:8];
            10: return m_cl[1][7:0];  11: return m_cl[1][15:8];
            16: return m_ch[0][7:0];  17: return m_ch[0][15:8];
            18: return m_ch[0][23:16];
            19: return m_ch[1][7:0];  20: return m_ch[1][15:8];
            21: return m_ch[1][23:16];
            24: return m_cap[7:0];
            25, 26, 27, 28: return m_hold[8*(a-25) +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(bit [5:0] a);
        if (!rst_n) return "R1 reset";
        if (a >= 24 && a <= 28) return "R2/R3/R4/R5/R11/R12 capture read";
        if (a == 2) return "R3/R6/R7/R9 flags read";
        return "R1 register read";
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk(tag_of(addr), rdata, exp_rd(addr));
            chk("R6/R7/R8 strobes", cmp, m_stb);
            chk("R10 irq", irq, |(m_flg & m_msk));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0; evt = 0;
    endtask

    task automatic wr(input bit [5:0] a, input bit [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; rd_en = 0; evt = 0; addr = a; wdata = d;
    endtask

    task automatic rd(input bit [5:0] a, output bit [7:0] v);
        @(negedge clk); #1;
        wr_en = 0; rd_en = 1; evt = 0; addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse_evt();
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0; evt = 1;
    endtask

    task automatic rd_cap(output bit [39:0] v);
        bit [7:0] b;
        rd(24, b); v[7:0] = b;
        for (int k = 1; k < 5; k++) begin
            rd(6'(24 + k), b); v[8*k +: 8] = b;
        end
    endtask

    task automatic stage(input bit [39:0] v);
        for (int b = 0; b < 5; b++) wr(6'(32 + b), v[8*b +: 8]);
    endtask

    initial begin
        #1000000;
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        bit [7:0]  b;
        bit [39:0] c1, c2;
        int n0, n1, n2;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;

        // R1: reset values
        rd(4, b); chk("R1 period low", b, 8'hFF);
        rd(5, b); chk("R1 period high", b, 8'hFF);
        rd(0, b); chk("R1 control", b, 8'h00);
        rd(2, b); chk("R1 flags", b, 8'h00);
        chk("R1 strobes", cmp, 4'h0);
        chk("R1 irq", irq, 1'b0);

        // R11 load, then R12 hold while stopped
        stage(40'h12_3456_0007);
        wr(0, 8'h02);
        tick(); tick();
        pulse_evt(); tick();
        rd_cap(c1); chk("R11 loaded value captured", c1, 40'h12_3456_0007);
        repeat (5) tick();
        pulse_evt(); tick();
        rd_cap(c2); chk("R12 counters held", c2, c1);

        // R2/R3: period 9 counts ten values per period
        wr(4, 8'd9); wr(5, 8'd0);
        stage(40'h0);
        wr(0, 8'h03);
        repeat (23) tick();
        pulse_evt(); tick();
        wr(0, 8'h00);
        rd_cap(c1); chk("R2/R3 count and coarse step", c1, 40'h00_0002_0003);

        // R3: coarse wrap from all ones sets flag bit 4
        wr(2, 8'h3F);
        stage(40'hFF_FFFF_0009);
        wr(0, 8'h03);
        tick();
        rd(2, b); chk("R3 wrap flag", b[4], 1'b1);
        wr(0, 8'h00);
        pulse_evt(); tick();
        rd_cap(c1); chk("R3 coarse wrapped to zero", c1[39:16], 24'h0);
        wr(2, 8'h3F);

        // R6 / R8: fine compare 0 enabled, fine compare 1 disabled
        wr(8, 8'd5);  wr(9, 8'd0);
        wr(10, 8'd7); wr(11, 8'd0);
        stage(40'h0);
        wr(0, 8'h07);
        n0 = 0; n1 = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (cmp[0]) n0++;
            if (cmp[1]) n1++;
        end
        chk("R6 fine strobe count", n0, 2);
        chk("R8 disabled strobe count", n1, 0);
        wr(0, 8'h00);
        rd(2, b); chk("R6/R8 flags", b, 8'h01);
        wr(2, 8'h3F);

        // R7: coarse compare 0 at value 3, period 1
        wr(4, 8'd1); wr(5, 8'd0);
        wr(16, 8'd3); wr(17, 8'd0); wr(18, 8'd0);
        stage(40'h0);
        wr(0, 8'h13);
        n2 = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (cmp[2]) n2++;
        end
        chk("R7 coarse strobe count", n2, 1);
        wr(0, 8'h00);
        rd(2, b); chk("R7 coarse flag", b[2], 1'b1);
        wr(2, 8'h3F);

        // R5: event and low-byte read in the same cycle
        stage(40'h0A_0B0C_0D0E);
        wr(0, 8'h02);
        pulse_evt();
        stage(40'h11_1213_1415);
        wr(0, 8'h02);
        @(negedge clk); #1;
        wr_en = 0; rd_en = 1; evt = 1; addr = 24;
        #1 chk("R5 low byte from earlier capture", rdata, 8'h0E);
        rd(25, b); chk("R5 held byte 1", b, 8'h0D);
        rd(28, b); chk("R5 held byte 4", b, 8'h0A);
        rd_cap(c1); chk("R4 new capture", c1, 40'h11_1213_1415);

        // R9: set and clear in the same cycle, set wins
        wr(4, 8'd0); wr(5, 8'd0);
        wr(8, 8'd0); wr(9, 8'd0);
        wr(2, 8'h3F);
        stage(40'h0);
        wr(0, 8'h07);
        tick();
        wr(2, 8'h01);
        tick();
        rd(2, b); chk("R9 set beats clear", b[0], 1'b1);
        wr(0, 8'h00);
        tick();
        wr(2, 8'h01);
        tick();
        rd(2, b); chk("R9 cleared when idle", b[0], 1'b0);
        wr(2, 8'h3F);

        // R10: unmasked capture flag raises irq
        wr(1, 8'h20);
        pulse_evt(); tick();
        chk("R10 irq raised", irq, 1'b1);
        wr(2, 8'h20); tick();
        chk("R10 irq dropped", irq, 1'b0);

        // mixed random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            bit [31:0] r;
            r = $urandom;
            @(negedge clk); #1;
            evt   = (r[2:0] == 3'd0);
            wr_en = (r[5:3] < 3'd2);
            rd_en = (r[5:3] >= 3'd5);
            addr  = r[11:6];
            wdata = r[19:12];
        end
        tick(); tick();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule